// File: doc/BRIEF.md
# Hardware Page Table Walker

This block resolves a translation miss by reading a four-level page table held in physical memory. A requester hands it a 48-bit virtual address together with the physical base of the top-level table. The walker then issues a chain of dependent 8-byte reads through a simple request/response memory port. When the walk ends it returns a physical page number and a page-size code, or a fault flag. Every access the walker makes uses a physical address, so it never needs a translation of its own.

A small fully associative directory cache keeps, for each recently walked 2 MiB region, the physical base of the last-level table that serves it. A lookup that hits skips the three upper levels and needs only one read. A leaf found at the 2 MiB level or at the 1 GiB level ends the walk early. Because of both effects, a walk takes between one and four reads. When the final entry has its accessed flag clear, the walker writes the entry back with the flag set before it reports the result. The walker handles one walk at a time, and a flush input empties the directory cache.

Top module: `ptw_walker`

## Requirements
- R1: After reset, req_ready is 1, and mem_req_valid and res_valid are 0.
- R2: On a directory-cache miss, the walk reads four entries in turn, starting from req_root (its low 12 bits are ignored). The entry at each level is read at table base + index*8, with indices taken from vaddr[47:39], [38:30], [29:21] and [20:12] in that order. Each non-leaf entry gives the next table base in bits [PA_W-1:12]. A last-level result returns that entry's bits [PA_W-1:12] as res_ppn, with res_size = 0.
- R3: Only one walk is active at a time. req_ready is 0 from the cycle after a request is accepted until the result has been given. A memory request is held with a stable address until mem_req_ready accepts it, and each request waits for its response before the next is issued.
- R4: Entry bit 7 marks a leaf. It is honoured only at the vaddr[29:21] level, which maps a 2 MiB page (res_size = 1, res_ppn = entry ppn with its low 9 bits replaced by vaddr[20:12]), and at the vaddr[38:30] level, which maps a 1 GiB page (res_size = 2, res_ppn low 18 bits replaced by vaddr[29:12]). A leaf ends the walk with no further reads.
- R5: An entry read with bit 0 (present) clear ends the walk at once with res_fault = 1, res_ppn = 0 and res_size = 0. No further read and no write follow.
- R6: If the final entry has bit 5 (accessed) clear, the walker writes that entry back to the same address with bit 5 set, and gives the result only after the write response. If bit 5 is already set, no write takes place.
- R7: After a present non-leaf entry is read at the vaddr[29:21] level, a later walk with the same vaddr[47:21] hits the directory cache and needs exactly one read. Leaf entries are not cached. No tag is ever held twice.
- R8: The directory cache holds 32 entries and replaces them round-robin. The 33rd fill after a flush evicts the first region filled.
- R9: A flush pulse invalidates every directory-cache entry. A walk that is in progress during a flush, including the cycle in which it was accepted, completes normally but does not fill the cache.
- R10: res_valid is a single-cycle pulse, and it carries res_ppn, res_size and res_fault for the walk just completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate the directory cache |
| req_valid | input | 1 | Walk request present |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_vaddr | input | 48 | Virtual address to translate |
| req_root | input | PA_W | Physical base of the top-level table |
| res_valid | output | 1 | Result pulse |
| res_fault | output | 1 | Walk hit a non-present entry |
| res_size | output | 2 | 0 = 4 KiB, 1 = 2 MiB, 2 = 1 GiB |
| res_ppn | output | PA_W-12 | Physical page number at 4 KiB granularity |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = write-back of the accessed flag, 0 = read |
| mem_req_addr | output | PA_W | Physical address of the 8-byte entry |
| mem_req_wdata | output | 64 | Entry value to write |
| mem_rsp_valid | input | 1 | Response for the outstanding request |
| mem_rsp_data | input | 64 | Entry data, ignored for write responses |

## Verification
The bench counts the reads and writes of every walk, so it can tell whether the walk length and the write-back are right. A walker that skipped the cache, or that cached leaf entries, would show the wrong number of reads. So would a walker that ignored the leaf bit at the 2 MiB and 1 GiB levels, and the spliced page number would also be wrong. A walker that filled the cache while a flush arrived mid-walk would show one read instead of four on the next walk to that region. Replacement that was not round-robin would evict the wrong region after the 33rd fill. The bench also checks that a fault is reported without a write, and that an entry which already has its accessed flag set is not written again.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int IDX_W    = 9;
    localparam int PG_SH    = 12;
    localparam int LVLS     = 4;
    localparam int VA_W     = PG_SH + LVLS * IDX_W;
    localparam int VPN_W    = VA_W - PG_SH;
    localparam int PTE_W    = 64;
    localparam int BIT_P    = 0;
    localparam int BIT_A    = 5;
    localparam int BIT_LEAF = 7;
    localparam int DC_TAG_W = VA_W - PG_SH - IDX_W;

    typedef enum logic [2:0] {
        ST_IDLE, ST_RD_REQ, ST_RD_WAIT, ST_WR_REQ, ST_WR_WAIT, ST_DONE
    } walk_st_e;

    typedef enum logic [1:0] {
        SZ_4K = 2'd0, SZ_2M = 2'd1, SZ_1G = 2'd2
    } pg_size_e;
endpackage

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr
    import ptw_pkg::*;
#(
    parameter int PA_W = 40
) (
    input  logic [VPN_W-1:0]      vpn,
    input  logic [1:0]            lvl,
    input  logic [PA_W-PG_SH-1:0] tbl,
    output logic [PA_W-1:0]       addr
);
    logic [IDX_W-1:0] idx;

    always_comb begin
        idx  = vpn[lvl*IDX_W +: IDX_W];
        addr = {tbl, idx, 3'b000};
    end
endmodule

// File: rtl/ptw_pte_decode.sv
module ptw_pte_decode
    import ptw_pkg::*;
#(
    parameter int PA_W = 40
) (
    input  logic                  raw_p,
    input  logic                  raw_leaf,
    input  logic [PA_W-PG_SH-1:0] raw_ppn,
    input  logic [1:0]            lvl,
    input  logic [2*IDX_W-1:0]    vpn_lo,
    output logic                  present,
    output logic                  leaf,
    output logic [PA_W-PG_SH-1:0] leaf_ppn,
    output logic [1:0]            size
);
    localparam int PN_W = PA_W - PG_SH;

    logic [PN_W-1:0] keep_mask;

    always_comb begin
        present = raw_p;
        leaf    = (lvl == 2'd0) || (raw_leaf && (lvl == 2'd1 || lvl == 2'd2));
        size    = SZ_4K;
        keep_mask = '1;
        if (raw_leaf && lvl == 2'd1) begin
            size      = SZ_2M;
            keep_mask = ~PN_W'({IDX_W{1'b1}});
        end else if (raw_leaf && lvl == 2'd2) begin
            size      = SZ_1G;
            keep_mask = ~PN_W'({2*IDX_W{1'b1}});
        end
        leaf_ppn = (raw_ppn & keep_mask) | (PN_W'(vpn_lo) & ~keep_mask);
    end
endmodule

// File: rtl/ptw_dir_cache.sv
module ptw_dir_cache #(
    parameter int ENTRIES = 32,
    parameter int TAG_W   = 27,
    parameter int DAT_W   = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_hit,
    output logic [DAT_W-1:0] lk_data,
    input  logic             fill_en,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic [DAT_W-1:0] fill_data
);
    localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    typedef struct packed {
        logic [ENTRIES-1:0]            vld;
        logic [ENTRIES-1:0][TAG_W-1:0] tag;
        logic [ENTRIES-1:0][DAT_W-1:0] dat;
        logic [PTR_W-1:0]              ptr;
    } dc_t;

    dc_t q, d;
    logic [ENTRIES-1:0] hit_vec;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hit_vec[g] = q.vld[g] && (q.tag[g] == lk_tag);
    end

    always_comb begin
        lk_data = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_vec[i]) lk_data = lk_data | q.dat[i];
        end
        lk_hit = |hit_vec;
    end

    always_comb begin
        d = q;
        if (flush) begin
            d.vld = '0;
            d.ptr = '0;
        end else if (fill_en) begin
            d.vld[q.ptr] = 1'b1;
            d.tag[q.ptr] = fill_tag;
            d.dat[q.ptr] = fill_data;
            d.ptr = (q.ptr == PTR_W'(ENTRIES - 1)) ? '0 : q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R7
    dup_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    // R9
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (q.vld == '0));
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int PA_W       = 40,
    parameter int DC_ENTRIES = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  flush,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [VA_W-1:0]       req_vaddr,
    input  logic [PA_W-1:0]       req_root,
    output logic                  res_valid,
    output logic                  res_fault,
    output logic [1:0]            res_size,
    output logic [PA_W-PG_SH-1:0] res_ppn,
    output logic                  mem_req_valid,
    input  logic                  mem_req_ready,
    output logic                  mem_req_write,
    output logic [PA_W-1:0]       mem_req_addr,
    output logic [PTE_W-1:0]      mem_req_wdata,
    input  logic                  mem_rsp_valid,
    input  logic [PTE_W-1:0]      mem_rsp_data
);
    localparam int PN_W = PA_W - PG_SH;

    typedef struct packed {
        walk_st_e         st;
        logic [VPN_W-1:0] vpn;
        logic [PN_W-1:0]  tbl;
        logic [1:0]       lvl;
        logic             no_fill;
        logic [PTE_W-1:0] pte;
        logic [PN_W-1:0]  ppn;
        logic [1:0]       size;
        logic             fault;
    } walk_t;

    walk_t q, d;

    logic            dc_hit;
    logic [PN_W-1:0] dc_data;
    logic            dc_fill;
    logic            dec_present;
    logic            dec_leaf;
    logic [PN_W-1:0] dec_ppn;
    logic [1:0]      dec_size;
    logic            unused_low;

    assign unused_low = ^{req_vaddr[PG_SH-1:0], req_root[PG_SH-1:0]};

    ptw_dir_cache #(
        .ENTRIES (DC_ENTRIES),
        .TAG_W   (DC_TAG_W),
        .DAT_W   (PN_W)
    ) i_dir_cache (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .lk_tag    (req_vaddr[VA_W-1:VA_W-DC_TAG_W]),
        .lk_hit    (dc_hit),
        .lk_data   (dc_data),
        .fill_en   (dc_fill),
        .fill_tag  (q.vpn[VPN_W-1:VPN_W-DC_TAG_W]),
        .fill_data (mem_rsp_data[PA_W-1:PG_SH])
    );

    ptw_entry_addr #(.PA_W(PA_W)) i_entry_addr (
        .vpn  (q.vpn),
        .lvl  (q.lvl),
        .tbl  (q.tbl),
        .addr (mem_req_addr)
    );

    ptw_pte_decode #(.PA_W(PA_W)) i_pte_decode (
        .raw_p    (mem_rsp_data[BIT_P]),
        .raw_leaf (mem_rsp_data[BIT_LEAF]),
        .raw_ppn  (mem_rsp_data[PA_W-1:PG_SH]),
        .lvl      (q.lvl),
        .vpn_lo   (q.vpn[2*IDX_W-1:0]),
        .present  (dec_present),
        .leaf     (dec_leaf),
        .leaf_ppn (dec_ppn),
        .size     (dec_size)
    );

    assign dc_fill = (q.st == ST_RD_WAIT) && mem_rsp_valid && dec_present
                     && !dec_leaf && (q.lvl == 2'd1) && !q.no_fill && !flush;

    always_comb begin
        d = q;
        if (flush && q.st != ST_IDLE) d.no_fill = 1'b1;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.vpn     = req_vaddr[VA_W-1:PG_SH];
                    d.no_fill = flush;
                    d.fault   = 1'b0;
                    d.st      = ST_RD_REQ;
                    if (dc_hit && !flush) begin
                        d.tbl = dc_data;
                        d.lvl = 2'd0;
                    end else begin
                        d.tbl = req_root[PA_W-1:PG_SH];
                        d.lvl = 2'd3;
                    end
                end
            end
            ST_RD_REQ: begin
                if (mem_req_ready) d.st = ST_RD_WAIT;
            end
            ST_RD_WAIT: begin
                if (mem_rsp_valid) begin
                    if (!dec_present) begin
                        d.fault = 1'b1;
                        d.ppn   = '0;
                        d.size  = SZ_4K;
                        d.st    = ST_DONE;
                    end else if (dec_leaf) begin
                        d.pte  = mem_rsp_data;
                        d.ppn  = dec_ppn;
                        d.size = dec_size;
                        d.st   = mem_rsp_data[BIT_A] ? ST_DONE : ST_WR_REQ;
                    end else begin
                        d.tbl = mem_rsp_data[PA_W-1:PG_SH];
                        d.lvl = q.lvl - 2'd1;
                        d.st  = ST_RD_REQ;
                    end
                end
            end
            ST_WR_REQ: begin
                if (mem_req_ready) d.st = ST_WR_WAIT;
            end
            ST_WR_WAIT: begin
                if (mem_rsp_valid) d.st = ST_DONE;
            end
            ST_DONE: begin
                d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign req_ready     = (q.st == ST_IDLE);
    assign mem_req_valid = (q.st == ST_RD_REQ) || (q.st == ST_WR_REQ);
    assign mem_req_write = (q.st == ST_WR_REQ);
    assign mem_req_wdata = q.pte | (PTE_W'(1) << BIT_A);
    assign res_valid     = (q.st == ST_DONE);
    assign res_fault     = q.fault;
    assign res_size      = q.size;
    assign res_ppn       = q.ppn;

    // R3
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)));

    // R6
    acc_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_write) |-> mem_req_wdata[BIT_A]);

    // R10
    res_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);
endmodule

// File: tb/test_ptw_walker.sv
module test_ptw_walker;
    localparam int PA_W = 40;
    localparam int PN_W = PA_W - 12;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            flush = 1'b0;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic [47:0]     req_vaddr = '0;
    logic [PA_W-1:0] req_root = 40'h1000;
    logic            res_valid;
    logic            res_fault;
    logic [1:0]      res_size;
    logic [PN_W-1:0] res_ppn;
    logic            mem_req_valid;
    logic            mem_req_ready = 1'b0;
    logic            mem_req_write;
    logic [PA_W-1:0] mem_req_addr;
    logic [63:0]     mem_req_wdata;
    logic            mem_rsp_valid = 1'b0;
    logic [63:0]     mem_rsp_data = '0;

    always #4 clk = ~clk;

    ptw_walker #(.PA_W(PA_W), .DC_ENTRIES(32)) i_ptw_walker (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_root(req_root),
        .res_valid(res_valid), .res_fault(res_fault),
        .res_size(res_size), .res_ppn(res_ppn),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    typedef struct {
        logic [PN_W-1:0] ppn;
        logic [1:0]      size;
        logic            fault;
        int              nrd;
        int              nwr;
        string           rq;
    } exp_t;

    exp_t        sb_q[$];
    logic [63:0] mem [logic [PA_W-1:0]];
    int n_chk = 0;
    int n_err = 0;
    int n_rd = 0;
    int n_wr = 0;
    int cyc = 0;

    task automatic check(string rq, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    function automatic logic [63:0] mk_pte(logic [PN_W-1:0] pn, bit p, bit a, bit lf);
        return {24'd0, pn, 12'd0} | 64'(p) | (64'(a) << 5) | (64'(lf) << 7);
    endfunction

    function automatic logic [47:0] mk_va(int i3, int i2, int i1, int i0);
        return {9'(i3), 9'(i2), 9'(i1), 9'(i0), 12'h000};
    endfunction

    // memory model: one response per accepted request
    initial begin
        logic [PA_W-1:0] a;
        logic [63:0]     dv;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            cyc++;
            mem_req_ready = (cyc % 3) != 0;
            if (mem_req_valid && mem_req_ready && rst_n) begin
                a = mem_req_addr;
                if (mem_req_write) begin
                    mem[a] = mem_req_wdata;
                    n_wr++;
                    dv = '0;
                end else begin
                    dv = mem.exists(a) ? mem[a] : 64'd0;
                    n_rd++;
                end
                repeat (1 + (cyc % 2)) begin
                    @(negedge clk);
                    mem_req_ready = 1'b0;
                end
                mem_rsp_data  = dv;
                mem_rsp_valid = 1'b1;
            end
        end
    end

    // monitor: compares each result against the scoreboard
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (res_valid) begin
                if (sb_q.size() == 0) begin
                    check("R10", "unexpected result", 64'd1, 64'd0);
                end else begin
                    e = sb_q.pop_front();
                    check(e.rq, "fault", 64'(res_fault), 64'(e.fault));
                    check(e.rq, "ppn", 64'(res_ppn), 64'(e.ppn));
                    check(e.rq, "size", 64'(res_size), 64'(e.size));
                    check(e.rq, "reads", 64'(n_rd), 64'(e.nrd));
                    check(e.rq, "writes", 64'(n_wr), 64'(e.nwr));
                end
                n_rd = 0;
                n_wr = 0;
            end
        end
    end

    task automatic walk(logic [47:0] va, logic [PN_W-1:0] ppn, logic [1:0] sz,
                        bit f, int nrd, int nwr, string rq);
        exp_t e;
        e.ppn = ppn; e.size = sz; e.fault = f; e.nrd = nrd; e.nwr = nwr; e.rq = rq;
        sb_q.push_back(e);
        while (!req_ready) @(negedge clk);
        req_vaddr = va;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        // R3: second request held off while busy
        check("R3", "req_ready while busy", 64'(req_ready), 64'd0);
        while (sb_q.size() != 0) @(negedge clk);
    endtask

    task automatic pulse_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        // page tables
        mem[40'h1000] = mk_pte(28'h2, 1, 1, 0);
        mem[40'h2000] = mk_pte(28'h3, 1, 1, 0);
        for (int i = 0; i <= 32; i++) begin
            mem[40'h3000 + 40'(i * 8)] = mk_pte(28'h100 + 28'(i), 1, 1, 0);
            for (int j = 0; j < 2; j++)
                mem[(40'h100 + 40'(i)) * 40'h1000 + 40'(j * 8)] =
                    mk_pte(28'h50000 + 28'(i * 4 + j), 1, j == 1, 0);
        end
        mem[40'h3000 + 40'(40 * 8)] = mk_pte(28'h8000, 1, 0, 1);
        mem[40'h2000 + 40'h8]       = mk_pte(28'h40000, 1, 1, 1);

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "req_ready", 64'(req_ready), 64'd1);
        check("R1", "mem_req_valid", 64'(mem_req_valid), 64'd0);
        check("R1", "res_valid", 64'(res_valid), 64'd0);

        // R2 R6: full walk, accessed flag written back
        walk(mk_va(0, 0, 0, 0), 28'h50000, 2'd0, 0, 4, 1, "R2");
        check("R6", "written entry", mem[40'h100000], mk_pte(28'h50000, 1, 1, 0));
        // R7: same region hits the directory cache
        walk(mk_va(0, 0, 0, 1), 28'h50001, 2'd0, 0, 1, 0, "R7");
        // R6: flag now set, no write
        walk(mk_va(0, 0, 0, 0), 28'h50000, 2'd0, 0, 1, 0, "R6");
        // R5: fault at last level
        walk(mk_va(0, 0, 0, 9), 28'h0, 2'd0, 1, 1, 0, "R5");
        // R4: 2 MiB leaf, written back, then not cached
        walk(mk_va(0, 0, 40, 5), 28'h8005, 2'd1, 0, 3, 1, "R4");
        check("R6", "2M entry", mem[40'h3000 + 40'(40 * 8)], mk_pte(28'h8000, 1, 1, 1));
        walk(mk_va(0, 0, 40, 5), 28'h8005, 2'd1, 0, 3, 0, "R4 R7");
        // R4: 1 GiB leaf
        walk(mk_va(0, 1, 7, 3), 28'h40E03, 2'd2, 0, 2, 0, "R4");
        // R5: fault at top level
        walk(mk_va(1, 0, 0, 0), 28'h0, 2'd0, 1, 1, 0, "R5");
        // R9: flush invalidates
        pulse_flush();
        walk(mk_va(0, 0, 0, 1), 28'h50001, 2'd0, 0, 4, 0, "R9");
        // R9: flush during a walk blocks its fill
        fork
            walk(mk_va(0, 0, 2, 1), 28'h50009, 2'd0, 0, 4, 0, "R9");
            begin
                repeat (3) @(negedge clk);
                flush = 1'b1;
                @(negedge clk);
                flush = 1'b0;
            end
        join
        walk(mk_va(0, 0, 2, 1), 28'h50009, 2'd0, 0, 4, 0, "R9");
        walk(mk_va(0, 0, 2, 1), 28'h50009, 2'd0, 0, 1, 0, "R9");
        // R8: round-robin replacement
        pulse_flush();
        for (int i = 0; i <= 32; i++)
            walk(mk_va(0, 0, i, 1), 28'h50000 + 28'(i * 4 + 1), 2'd0, 0, 4, 0, "R8");
        walk(mk_va(0, 0, 0, 1), 28'h50001, 2'd0, 0, 4, 0, "R8");
        walk(mk_va(0, 0, 1, 1), 28'h50005, 2'd0, 0, 4, 0, "R8");
        walk(mk_va(0, 0, 3, 1), 28'h5000D, 2'd0, 0, 1, 0, "R8");
        walk(mk_va(0, 0, 32, 1), 28'h50081, 2'd0, 0, 1, 0, "R8");

        repeat (4) @(negedge clk);
        check("R10", "res_valid idle", 64'(res_valid), 64'd0);
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule